// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM burst. A small mode register holds the burst length and the beat ordering. A start pulse loads a 10-bit start column. From the next clock on, the block gives one column address per cycle and marks the final beat. A stop input ends a burst early. A full-page burst keeps running until it is stopped.

Sequential ordering counts up through the low bits of the column. It wraps inside an aligned block the size of the burst, and the upper bits stay fixed. Interleaved ordering XORs the start column with the beat index over the same low bits. Full page covers all 1024 columns. It is always sequential and wraps from 1023 to 0. A request for interleaved full page is stored as sequential and raises an illegal-request flag. Every burst latches its settings at start, so a later write to the mode register affects only the next burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), col_valid, col_last and cfg_illegal are 0. The mode is burst length 1 with sequential order.
- R2: start is sampled at a rising edge. At that edge col_valid becomes 1 and col_addr equals start_col (beat 0).
- R3: Sequential order (cfg_ilv=0). Beat b has low k bits equal to (start_col + b) mod 2^k and upper bits equal to those of start_col, where 2^k is the burst length.
- R4: Interleaved order (cfg_ilv=1) with a fixed length. Beat b has low k bits equal to start_col XOR b and upper bits unchanged.
- R5: cfg_len encodes the length: 0 is 1 beat, 1 is 2 beats, 2 is 4 beats, 3 is 8 beats, 7 is full page. A fixed-length burst gives exactly that many valid beats. col_last is 1 on the final beat only, and col_valid is 0 the cycle after it.
- R6: A full-page burst (cfg_len=7) adds 1 per beat modulo 1024, wrapping from 1023 to 0. It never asserts col_last and runs until it is stopped.
- R7: If stop is 1 at an edge during a burst and start is 0, the beat shown before that edge is the last valid beat. col_valid is 0 after the edge.
- R8: A mode write with cfg_len=7 and cfg_ilv=1 sets cfg_illegal and stores sequential order. Any later legal write without that combination clears cfg_illegal.
- R9: A mode write with a reserved length code (4, 5 or 6) is ignored. Length, order and cfg_illegal stay unchanged.
- R10: A mode write during a burst does not change the length or order of that burst.
- R11: start during a burst restarts at the new start_col. start has priority over a stop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 requests interleaved order |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 10 | Start column of the burst |
| stop | input | 1 | End the current burst early |
| col_valid | output | 1 | col_addr holds a burst beat |
| col_addr | output | 10 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |
| cfg_illegal | output | 1 | Last accepted write asked for interleaved full page |

## Verification
The assertions assume start and stop are never unknown after reset, and that start_col is stable in any cycle where start is high. They do not assume that stop appears only during a burst. A stop while idle must have no effect. The stimulus drives every input on the falling edge and keeps start_col stable across each start cycle. Random bursts use legal length codes with both orders. Stops land on random beats inside each burst. Full-page bursts are always stopped within a few dozen beats. Directed cases place reserved codes, mid-burst mode writes, restarts and start-with-stop collisions.

// File: rtl/colgen_pkg.sv
// Package: shared types for the burst column address generator.
// Assumes a 3-bit length code; codes 4..6 are reserved.
package colgen_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    typedef struct packed {
        len_code_e len;
        logic      ilv;
    } burst_mode_t;

endpackage

// File: rtl/colgen_mode_reg.sv
// Mode register: holds the burst length and order used by the next burst.
// Assumes cfg_len_i is only sampled when cfg_we_i is high. Reserved codes
// are dropped, and interleaved full page is stored as sequential and flagged.
module colgen_mode_reg
    import colgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we_i,
    input  logic [2:0]  cfg_len_i,
    input  logic        cfg_ilv_i,
    output burst_mode_t mode_o,
    output logic        illegal_o
);

    logic code_legal;
    logic is_page;

    // Decide whether the written length code is one the block supports.
    always_comb begin
        case (cfg_len_i)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd7: code_legal = 1'b1;
            default:                      code_legal = 1'b0;
        endcase
        is_page = (cfg_len_i == 3'd7);
    end

    // Store an accepted write; coerce interleaved full page to sequential.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o.len <= LEN_1;
            mode_o.ilv <= 1'b0;
            illegal_o  <= 1'b0;
        end else if (cfg_we_i && code_legal) begin
            mode_o.len <= len_code_e'(cfg_len_i);
            mode_o.ilv <= cfg_ilv_i && !is_page;
            illegal_o  <= cfg_ilv_i && is_page;
        end
    end

endmodule

// File: rtl/colgen_beat_ctr.sv
// Beat counter: latches the burst settings at start and steps one beat per
// clock until the final beat or a stop. Assumes mode_i is stable around start.
module colgen_beat_ctr
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             stop_i,
    input  burst_mode_t      mode_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             full_o,
    output logic             last_o
);

    logic [COL_W-1:0] mask_new;

    // Turn the length code into a mask of the wrapping low bits.
    always_comb begin
        case (mode_i.len)
            LEN_1:   mask_new = '0;
            LEN_2:   mask_new = COL_W'(1);
            LEN_4:   mask_new = COL_W'(3);
            LEN_8:   mask_new = COL_W'(7);
            default: mask_new = '1;
        endcase
    end

    // Flag the final beat of a fixed-length burst.
    always_comb last_o = active_o && !full_o && (beat_o == mask_o);

    // Run the burst state: start wins, then stop, then the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            beat_o   <= '0;
            base_o   <= '0;
            mask_o   <= '0;
            ilv_o    <= 1'b0;
            full_o   <= 1'b0;
        end else if (start_i) begin
            active_o <= 1'b1;
            beat_o   <= '0;
            base_o   <= start_col_i;
            mask_o   <= mask_new;
            ilv_o    <= mode_i.ilv;
            full_o   <= (mode_i.len == LEN_PAGE);
        end else if (active_o) begin
            if (stop_i || last_o) begin
                active_o <= 1'b0;
            end else begin
                beat_o <= beat_o + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/colgen_addr_map.sv
// Address map: combines the latched start column and the beat index into
// the beat's column. Assumes mask marks the low bits that wrap.
module colgen_addr_map #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] addr_o
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // Build both orderings, then keep the upper bits of the start column.
    always_comb begin
        low_seq = base_i + beat_i;
        low_ilv = base_i ^ beat_i;
        addr_o  = (base_i & ~mask_i) | ((ilv_i ? low_ilv : low_seq) & mask_i);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
// Top: SDRAM burst column address generator. Connects the mode register,
// the beat counter and the address map. Assumes start_col is stable in the
// cycle where start is high.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_ilv,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             cfg_illegal
);

    burst_mode_t      mode;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             burst_ilv;
    logic             burst_full;

    colgen_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we_i  (cfg_we),
        .cfg_len_i (cfg_len),
        .cfg_ilv_i (cfg_ilv),
        .mode_o    (mode),
        .illegal_o (cfg_illegal)
    );

    colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_col_i (start_col),
        .stop_i      (stop),
        .mode_i      (mode),
        .active_o    (col_valid),
        .beat_o      (beat),
        .base_o      (base),
        .mask_o      (mask),
        .ilv_o       (burst_ilv),
        .full_o      (burst_full),
        .last_o      (col_last)
    );

    colgen_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (base),
        .beat_i (beat),
        .mask_i (mask),
        .ilv_i  (burst_ilv),
        .addr_o (col_addr)
    );

endmodule

// File: rtl/colgen_checker.sv
// Checker: temporal properties of the column generator, bound to the top.
module colgen_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last,
    input logic             cfg_illegal,
    input logic             burst_full,
    input logic             burst_ilv
);

    // R2: a start gives beat 0 at the start column.
    assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));

    // R5: the final-beat flag only appears on a valid beat.
    assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R5: a burst goes on until its final beat unless stopped or restarted.
    assert_no_early_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !stop && !start) |=> col_valid);

    // R6: full page steps by one, modulo the column space.
    assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && burst_full && !start && !stop) |=>
            (col_addr == $past(col_addr) + COL_W'(1)));

    // R7: a stop without a start ends the burst at the edge.
    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop && !start) |=> !col_valid);

    // R8: full page never runs interleaved.
    assert_page_sequential_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && burst_full) |-> !burst_ilv);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_col   (start_col),
    .stop        (stop),
    .col_valid   (col_valid),
    .col_addr    (col_addr),
    .col_last    (col_last),
    .cfg_illegal (cfg_illegal),
    .burst_full  (burst_full),
    .burst_ilv   (burst_ilv)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic       cfg_ilv = 1'b0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic       stop = 1'b0;
    logic       col_valid;
    logic [9:0] col_addr;
    logic       col_last;
    logic       cfg_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_burst_colgen i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_ilv(cfg_ilv), .start(start), .start_col(start_col), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
        .cfg_illegal(cfg_illegal)
    );

    function automatic logic [9:0] ref_mask(input logic [2:0] code);
        return (code == 3'd7) ? 10'h3FF : 10'((1 << code) - 1);
    endfunction

    function automatic int ref_len(input logic [2:0] code);
        return (code == 3'd7) ? 1024 : (1 << code);
    endfunction

    function automatic logic [9:0] ref_addr(input logic [9:0] s, input logic [2:0] code,
                                            input logic ilv, input int b);
        logic [9:0] m;
        logic [9:0] lo;
        m  = ref_mask(code);
        lo = ilv ? (s ^ 10'(b)) : (s + 10'(b));
        return (s & ~m) | (lo & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [2:0] code, input logic ilv);
        cfg_we = 1'b1; cfg_len = code; cfg_ilv = ilv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one burst from the current falling edge. stop_at < 0 means no stop.
    // cfg_at >= 0 issues a mode write of (ncode, nilv) during that beat.
    task automatic run_burst(input logic [9:0] col, input logic [2:0] code, input logic ilv,
                             input int stop_at, input int cfg_at,
                             input logic [2:0] ncode, input logic nilv, input string req);
        int len;
        len = ref_len(code);
        start = 1'b1; start_col = col;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            start = 1'b0; stop = 1'b0; cfg_we = 1'b0;
            chk(col_valid == 1'b1, req, col_valid, 1);
            chk(col_addr == ref_addr(col, code, ilv, b), req, col_addr, ref_addr(col, code, ilv, b));
            chk(col_last == (code != 3'd7 && b == len - 1), req, col_last, (code != 3'd7 && b == len - 1));
            if (b == cfg_at) begin
                cfg_we = 1'b1; cfg_len = ncode; cfg_ilv = nilv;
            end
            if (b == stop_at) begin
                stop = 1'b1;
                break;
            end
        end
        @(negedge clk);
        stop = 1'b0; cfg_we = 1'b0;
        chk(col_valid == 1'b0, req, col_valid, 0);
    endtask

    initial begin
        logic [2:0] code;
        logic       ilv;
        int         sa;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        chk(col_valid == 0, "R1", col_valid, 0);
        chk(col_last == 0, "R1", col_last, 0);
        chk(cfg_illegal == 0, "R1", cfg_illegal, 0);
        // R1/R2: default mode gives a single-beat sequential burst
        run_burst(10'h2A5, 3'd0, 1'b0, -1, -1, 3'd0, 1'b0, "R1_R2");
        // R7: a stop while idle changes nothing
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk(col_valid == 0, "R7", col_valid, 0);
        // R3: sequential wrap inside the aligned block
        write_mode(3'd3, 1'b0);
        run_burst(10'h1FE, 3'd3, 1'b0, -1, -1, 3'd0, 1'b0, "R3");
        write_mode(3'd2, 1'b0);
        run_burst(10'h003, 3'd2, 1'b0, -1, -1, 3'd0, 1'b0, "R3");
        // R4: interleaved order
        write_mode(3'd3, 1'b1);
        run_burst(10'h0B5, 3'd3, 1'b1, -1, -1, 3'd0, 1'b0, "R4");
        write_mode(3'd1, 1'b1);
        run_burst(10'h3FF, 3'd1, 1'b1, -1, -1, 3'd0, 1'b0, "R4_R5");
        // R6: full page wraps from 1023 to 0, stopped after 12 beats
        write_mode(3'd7, 1'b0);
        chk(cfg_illegal == 0, "R8", cfg_illegal, 0);
        run_burst(10'h3FA, 3'd7, 1'b0, 11, -1, 3'd0, 1'b0, "R6_R7");
        // R8: interleaved full page is flagged and runs sequentially
        write_mode(3'd7, 1'b1);
        chk(cfg_illegal == 1, "R8", cfg_illegal, 1);
        run_burst(10'h3FD, 3'd7, 1'b0, 6, -1, 3'd0, 1'b0, "R8");
        // R9: a reserved code is ignored, so mode and flag stay the same
        write_mode(3'd5, 1'b0);
        chk(cfg_illegal == 1, "R9", cfg_illegal, 1);
        run_burst(10'h010, 3'd7, 1'b0, 3, -1, 3'd0, 1'b0, "R9");
        write_mode(3'd2, 1'b1);
        chk(cfg_illegal == 0, "R8", cfg_illegal, 0);
        write_mode(3'd6, 1'b0);
        run_burst(10'h122, 3'd2, 1'b1, -1, -1, 3'd0, 1'b0, "R9");
        // R7: stop mid-burst on a fixed length
        write_mode(3'd3, 1'b0);
        run_burst(10'h044, 3'd3, 1'b0, 2, -1, 3'd0, 1'b0, "R7");
        // R10: a mode write during a burst leaves it unchanged
        run_burst(10'h0F1, 3'd3, 1'b0, -1, 2, 3'd1, 1'b1, "R10");
        run_burst(10'h0F1, 3'd1, 1'b1, -1, -1, 3'd0, 1'b0, "R10");
        // R11: restart during a burst, with a stop in the same cycle
        write_mode(3'd3, 1'b0);
        start = 1'b1; start_col = 10'h100;
        for (int b = 0; b < 3; b++) begin
            @(negedge clk); start = 1'b0;
        end
        start = 1'b1; stop = 1'b1; start_col = 10'h20D;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(col_valid == 1 && col_addr == 10'h20D, "R11", col_addr, 10'h20D);
        @(negedge clk);
        chk(col_valid == 1 && col_addr == 10'h20E, "R11", col_addr, 10'h20E);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk(col_valid == 0, "R11", col_valid, 0);
        // Random bursts with random stops over R3..R7
        for (int n = 0; n < 60; n++) begin
            int pick;
            pick = $urandom_range(0, 4);
            code = (pick == 4) ? 3'd7 : 3'(pick);
            ilv  = (code == 3'd7) ? 1'b0 : 1'($urandom_range(0, 1));
            write_mode(code, ilv);
            if (code == 3'd7) sa = $urandom_range(0, 40);
            else sa = ($urandom_range(0, 2) == 0) ? $urandom_range(0, ref_len(code) - 1) : -1;
            run_burst(10'($urandom_range(0, 1023)), code, ilv, sa, -1, 3'd0, 1'b0, "R3_R4_R5_R6_R7");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule